// File: doc/BRIEF.md
# Multi-lane SPI flash command sequencer

This block runs one SPI flash transaction on the controller side from a command descriptor. The descriptor gives a transfer mode and five byte counts: opcode, address, write data, dummy and read data. The block produces the serial clock and an active-low chip select. It drives four data lanes, each with its own output enable, and samples the same four lanes on input. The lane width can change from one phase to the next, as the mode selects.

The bytes to be sent are pulled from a byte-stream input one at a time with a take strobe. Each captured byte leaves on a byte-stream output with a one-cycle valid strobe. A one-cycle start launches a command. Busy stays high while the command runs, and done pulses once at the end. The serial clock runs at half the system clock. A command with every count at zero completes at once and leaves the bus idle.

Top module: `mio_flash_seq`

## Requirements
- R1: After start, byte segments are transferred in this fixed order: opcode, address, write data, dummy, read data. Segments with a count of zero are skipped.
- R2: The mode field sets the lane width of each segment. Mode 5 sends the opcode on 4 lanes and every other mode on 1 lane. The address uses 2 lanes in mode 2, 4 lanes in modes 4 and 5, and 1 lane otherwise. Write, dummy and read bytes use 1 lane in mode 0, 2 lanes in modes 1 and 2, and 4 lanes in modes 3, 4 and 5. While a byte is being driven, exactly lanes 0 to width-1 have their output enable set.
- R3: Outgoing bytes go out most significant bit first. On a beat of k lanes, lane k-1 carries the most significant bit of the group. Single-lane output uses lane 0.
- R4: Dummy bytes keep all output enables low, and so do read bytes. A dummy byte lasts 8 divided by the data-segment lane width SCLK periods.
- R5: Single-lane reads sample lane 1 only. Reads on k lanes sample lanes 0 to k-1, with lane k-1 as the most significant bit. Each read byte is assembled MSB first and delivered on rx_data with a one-cycle rx_valid. Exactly the read count of bytes is delivered.
- R6: Each opcode, address or write byte consumes one tx_data byte. tx_take is high for one cycle in the clock just before that byte's first group appears. The total number of takes equals opcode plus address plus write counts.
- R7: SCLK idles low. Each SCLK period is two clocks, low then high. Data changes only where SCLK falls, and input is sampled at the end of the high half.
- R8: cs_n goes low together with the first driven group and stays low through the last beat. It is then high, with SCLK low, for two clocks, and done pulses in the clock that follows.
- R9: A command whose counts are all zero pulses done in the clock after start. cs_n stays high and SCLK stays low throughout.
- R10: busy is high from the clock after start through the done clock. A start seen while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a command, sampled while idle |
| mode | input | 3 | Transfer mode 0..5 |
| op_len | input | LEN_W | Opcode byte count |
| adr_len | input | LEN_W | Address byte count |
| wr_len | input | LEN_W | Write byte count |
| hz_len | input | LEN_W | Dummy byte count |
| rd_len | input | LEN_W | Read byte count |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| tx_data | input | 8 | Next byte to send |
| tx_take | output | 1 | tx_data consumed this cycle |
| rx_data | output | 8 | Captured byte |
| rx_valid | output | 1 | rx_data valid pulse |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| io_out | output | 4 | Lane output values |
| io_oe | output | 4 | Lane output enables |
| io_in | input | 4 | Lane input values |

## Verification
The assertions assume three things about the inputs: the mode is always one of 0 to 5, tx_data already holds the next byte whenever tx_take is high, and io_in does not change across the edge that ends an SCLK high half. The bench keeps to all three. It uses only valid modes and serves tx_data from a table indexed by its own count of takes. It changes io_in at clock midpoints, which are always away from the sampling edge. The bench also fills lanes it does not expect to be read with random values, and it raises start again in the middle of one command, so the block has to ignore that stimulus.

// File: rtl/spiseq_pkg.sv
package spiseq_pkg;
    localparam int LANES  = 4;
    localparam int BYTE_W = 8;
    localparam int NSEG   = 5;
    localparam int BEAT_W = 4;

    typedef enum logic [2:0] {
        M_111 = 3'd0, M_112 = 3'd1, M_122 = 3'd2,
        M_114 = 3'd3, M_144 = 3'd4, M_444 = 3'd5
    } xfer_mode_e;

    typedef enum logic [2:0] {
        SEG_OP = 3'd0, SEG_ADR = 3'd1, SEG_WR = 3'd2, SEG_HZ = 3'd3, SEG_RD = 3'd4
    } seg_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_LO, ST_HI, ST_GAP, ST_DONE
    } seq_st_e;

    typedef struct packed {
        logic hit;
        seg_e seg;
    } seg_pick_t;

    // log2 of the lane width used by a segment in a given mode
    function automatic logic [1:0] seg_lw(xfer_mode_e m, seg_e s);
        logic [1:0] r;
        case (s)
            SEG_OP:  r = (m == M_444) ? 2'd2 : 2'd0;
            SEG_ADR: begin
                case (m)
                    M_122:        r = 2'd1;
                    M_144, M_444: r = 2'd2;
                    default:      r = 2'd0;
                endcase
            end
            default: begin
                case (m)
                    M_112, M_122:        r = 2'd1;
                    M_114, M_144, M_444: r = 2'd2;
                    default:             r = 2'd0;
                endcase
            end
        endcase
        return r;
    endfunction

    function automatic logic [BEAT_W-1:0] beats_of(logic [1:0] lw);
        return BEAT_W'(BYTE_W >> lw);
    endfunction

    // lowest-numbered non-empty segment at or after 'from'
    function automatic seg_pick_t pick_seg(logic [NSEG-1:0] nz, int from);
        seg_pick_t p;
        p.hit = 1'b0;
        p.seg = SEG_OP;
        for (int i = NSEG - 1; i >= 0; i--) begin
            if (i >= from && nz[i]) begin
                p.hit = 1'b1;
                p.seg = seg_e'(3'(i));
            end
        end
        return p;
    endfunction
endpackage

// File: rtl/spiseq_ctrl.sv
module spiseq_ctrl
    import spiseq_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [2:0]       mode,
    input  logic [LEN_W-1:0] op_len,
    input  logic [LEN_W-1:0] adr_len,
    input  logic [LEN_W-1:0] wr_len,
    input  logic [LEN_W-1:0] hz_len,
    input  logic [LEN_W-1:0] rd_len,
    output logic             load,
    output logic             load_tx,
    output logic             step,
    output logic             byte_end,
    output logic             capture,
    output logic             drive_en,
    output logic [1:0]       lw,
    output logic             sclk,
    output logic             cs_n,
    output logic             busy,
    output logic             done
);
    seq_st_e    st;
    seg_e       seg, load_seg;
    xfer_mode_e mode_q, mode_in;
    logic [LEN_W-1:0]  lens_q  [NSEG];
    logic [LEN_W-1:0]  lens_in [NSEG];
    logic [NSEG-1:0]   nz_in, nz_q;
    logic [LEN_W-1:0]  left_q;
    logic [BEAT_W-1:0] beat_q;
    logic              gap_q;
    seg_pick_t         first_p, next_p;
    logic              last_beat, more_bytes;

    always_comb begin
        lens_in[0] = op_len;
        lens_in[1] = adr_len;
        lens_in[2] = wr_len;
        lens_in[3] = hz_len;
        lens_in[4] = rd_len;
        for (int i = 0; i < NSEG; i++) begin
            nz_in[i] = |lens_in[i];
            nz_q[i]  = |lens_q[i];
        end
    end

    assign mode_in    = xfer_mode_e'(mode);
    assign first_p    = pick_seg(nz_in, 0);
    assign next_p     = pick_seg(nz_q, int'(seg) + 1);
    assign last_beat  = (beat_q == BEAT_W'(1));
    assign more_bytes = (left_q != LEN_W'(1));
    assign lw         = seg_lw(mode_q, seg);

    always_comb begin
        load     = 1'b0;
        load_seg = seg;
        if (st == ST_IDLE && start && first_p.hit) begin
            load     = 1'b1;
            load_seg = first_p.seg;
        end else if (st == ST_HI && last_beat) begin
            if (more_bytes) begin
                load = 1'b1;
            end else if (next_p.hit) begin
                load     = 1'b1;
                load_seg = next_p.seg;
            end
        end
    end

    assign load_tx  = load && (load_seg <= SEG_WR);
    assign step     = (st == ST_HI);
    assign byte_end = step && last_beat;
    assign capture  = (seg == SEG_RD);
    assign sclk     = (st == ST_HI);
    assign cs_n     = !(st == ST_LO || st == ST_HI);
    assign drive_en = !cs_n && (seg <= SEG_WR);
    assign busy     = (st != ST_IDLE);
    assign done     = (st == ST_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            seg    <= SEG_OP;
            mode_q <= M_111;
            left_q <= '0;
            beat_q <= '0;
            gap_q  <= 1'b0;
            for (int i = 0; i < NSEG; i++) lens_q[i] <= '0;
        end else begin
            case (st)
                ST_IDLE: if (start) begin
                    mode_q <= mode_in;
                    for (int i = 0; i < NSEG; i++) lens_q[i] <= lens_in[i];
                    if (first_p.hit) begin
                        seg    <= first_p.seg;
                        left_q <= lens_in[first_p.seg];
                        beat_q <= beats_of(seg_lw(mode_in, first_p.seg));
                        st     <= ST_LO;
                    end else begin
                        st <= ST_DONE;
                    end
                end
                ST_LO: st <= ST_HI;
                ST_HI: begin
                    if (!last_beat) begin
                        beat_q <= beat_q - BEAT_W'(1);
                        st     <= ST_LO;
                    end else if (load) begin
                        seg    <= load_seg;
                        left_q <= more_bytes ? left_q - LEN_W'(1) : lens_q[load_seg];
                        beat_q <= beats_of(seg_lw(mode_q, load_seg));
                        st     <= ST_LO;
                    end else begin
                        gap_q <= 1'b0;
                        st    <= ST_GAP;
                    end
                end
                ST_GAP: begin
                    if (gap_q) st <= ST_DONE;
                    else gap_q <= 1'b1;
                end
                ST_DONE: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R1: a beat that is not the last of its byte stays in the same segment
    assert_seg_held_R1: assert property (@(posedge clk) disable iff (rst)
        (st == ST_HI && !last_beat) |=> (st == ST_LO && $stable(seg)))
        else $error("segment changed mid-byte");
endmodule

// File: rtl/spiseq_lanes.sv
module spiseq_lanes
    import spiseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              load_tx,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              step,
    input  logic              byte_end,
    input  logic              capture,
    input  logic              drive_en,
    input  logic [1:0]        lw,
    input  logic [LANES-1:0]  io_in,
    output logic [LANES-1:0]  io_out,
    output logic [LANES-1:0]  io_oe,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid
);
    logic [BYTE_W-1:0] sh_q, sh_next;
    logic [LANES-1:0]  in_bits, lane_mask, grp;

    always_comb begin
        case (lw)
            2'd1: begin
                lane_mask = 4'b0011;
                in_bits   = {2'b00, io_in[1:0]};
                grp       = {2'b00, sh_q[BYTE_W-1 -: 2]};
            end
            2'd2: begin
                lane_mask = 4'b1111;
                in_bits   = io_in;
                grp       = sh_q[BYTE_W-1 -: 4];
            end
            default: begin
                lane_mask = 4'b0001;
                in_bits   = {3'b000, io_in[1]};
                grp       = {3'b000, sh_q[BYTE_W-1]};
            end
        endcase
        sh_next = (sh_q << (1 << lw)) | (capture ? BYTE_W'(in_bits) : '0);
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign io_oe[i]  = drive_en & lane_mask[i];
        assign io_out[i] = drive_en & lane_mask[i] & grp[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q     <= '0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= byte_end && capture;
            if (byte_end && capture) rx_data <= sh_next;
            if (load) sh_q <= load_tx ? tx_byte : '0;
            else if (step) sh_q <= sh_next;
        end
    end

    // R4: no lane is driven while read data is being sampled
    assert_quiet_read_R4: assert property (@(posedge clk) disable iff (rst)
        (step && capture) |-> (io_oe == '0))
        else $error("lane driven during read");

    // R5: every read byte spans at least two clocks
    assert_rx_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid)
        else $error("rx_valid longer than one cycle");
endmodule

// File: rtl/mio_flash_seq.sv
module mio_flash_seq
    import spiseq_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [2:0]       mode,
    input  logic [LEN_W-1:0] op_len,
    input  logic [LEN_W-1:0] adr_len,
    input  logic [LEN_W-1:0] wr_len,
    input  logic [LEN_W-1:0] hz_len,
    input  logic [LEN_W-1:0] rd_len,
    output logic             busy,
    output logic             done,
    input  logic [7:0]       tx_data,
    output logic             tx_take,
    output logic [7:0]       rx_data,
    output logic             rx_valid,
    output logic             sclk,
    output logic             cs_n,
    output logic [3:0]       io_out,
    output logic [3:0]       io_oe,
    input  logic [3:0]       io_in
);
    logic       load, load_tx, step, byte_end, capture, drive_en;
    logic [1:0] lw;

    spiseq_ctrl #(.LEN_W(LEN_W)) u_ctrl (
        .clk(clk), .rst(rst), .start(start), .mode(mode),
        .op_len(op_len), .adr_len(adr_len), .wr_len(wr_len),
        .hz_len(hz_len), .rd_len(rd_len),
        .load(load), .load_tx(load_tx), .step(step), .byte_end(byte_end),
        .capture(capture), .drive_en(drive_en), .lw(lw),
        .sclk(sclk), .cs_n(cs_n), .busy(busy), .done(done)
    );

    spiseq_lanes u_lanes (
        .clk(clk), .rst(rst), .load(load), .load_tx(load_tx), .tx_byte(tx_data),
        .step(step), .byte_end(byte_end), .capture(capture), .drive_en(drive_en),
        .lw(lw), .io_in(io_in), .io_out(io_out), .io_oe(io_oe),
        .rx_data(rx_data), .rx_valid(rx_valid)
    );

    assign tx_take = load_tx;

    // R7: SCLK high lasts exactly one clock
    assert_sclk_half_R7: assert property (@(posedge clk) disable iff (rst)
        sclk |=> !sclk)
        else $error("sclk high too long");

    // R7: lanes do not change on the rising SCLK edge
    assert_launch_on_fall_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk) |-> ($stable(io_out) && $stable(io_oe)))
        else $error("lane changed at rising sclk");

    // R8: chip select already released before done
    assert_release_before_done_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> (cs_n && $past(cs_n)))
        else $error("done while selected");

    // R6: a taken byte is driven in the following clock
    assert_take_drives_R6: assert property (@(posedge clk) disable iff (rst)
        tx_take |=> (io_oe != 4'b0000))
        else $error("take without drive");

    // R10: an accepted start makes the block busy
    assert_start_busy_R10: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy)
        else $error("start not accepted");
endmodule

// File: tb/test_mio_flash_seq.sv
module test_mio_flash_seq;
    localparam int LEN_W = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [2:0] mode = 3'd0;
    logic [LEN_W-1:0] op_len = '0, adr_len = '0, wr_len = '0, hz_len = '0, rd_len = '0;
    logic busy, done, tx_take, rx_valid, sclk, cs_n;
    logic [7:0] tx_data, rx_data;
    logic [3:0] io_out, io_oe;
    logic [3:0] io_in = 4'd0;

    int checks = 0;
    int errors = 0;
    int take_cnt = 0;
    logic [7:0] tx_mem [256];
    logic [7:0] rx_mem [256];

    always #10 clk = ~clk;

    mio_flash_seq #(.LEN_W(LEN_W)) i_mio_flash_seq (
        .clk(clk), .rst(rst), .start(start), .mode(mode),
        .op_len(op_len), .adr_len(adr_len), .wr_len(wr_len),
        .hz_len(hz_len), .rd_len(rd_len),
        .busy(busy), .done(done), .tx_data(tx_data), .tx_take(tx_take),
        .rx_data(rx_data), .rx_valid(rx_valid), .sclk(sclk), .cs_n(cs_n),
        .io_out(io_out), .io_oe(io_oe), .io_in(io_in)
    );

    assign tx_data = tx_mem[take_cnt[7:0]];
    always @(posedge clk) if (tx_take) take_cnt <= take_cnt + 1;

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // lane width per segment, taken from the mode table (R2)
    function automatic int lanes_for(int md, int sg);
        if (sg == 0) return (md == 5) ? 4 : 1;
        if (sg == 1) return (md == 2) ? 2 : ((md == 4 || md == 5) ? 4 : 1);
        return (md == 0) ? 1 : ((md <= 2) ? 2 : 4);
    endfunction

    task automatic run_cmd(int md, int ol, int al, int wl, int hl, int rl, bit poke);
        int lens [5];
        int e_sclk[$], e_cs[$], e_oe[$], e_out[$], e_done[$], b_in[$];
        int base, txk, rxk, nb, n, got;
        bit empty;
        string qt;
        lens = '{ol, al, wl, hl, rl};
        base = take_cnt;
        txk = 0;
        rxk = 0;
        for (int k = 0; k < 256; k++) rx_mem[k] = 8'($urandom);
        // behavioural model: beat list in segment order (R1)
        for (int sg = 0; sg < 5; sg++) begin
            int w, m;
            w = lanes_for(md, sg);
            m = (1 << w) - 1;
            for (int j = 0; j < lens[sg]; j++) begin
                int byt;
                if (sg <= 2) begin byt = int'(tx_mem[(base + txk) % 256]); txk++; end
                else if (sg == 4) begin byt = int'(rx_mem[rxk]); rxk++; end
                else byt = 0;
                for (int g = 0; g < 8 / w; g++) begin
                    int bits, oe, outv, inv, rnd;
                    bits = (byt >> (8 - w * (g + 1))) & m;
                    oe   = (sg <= 2) ? m : 0;
                    outv = (sg <= 2) ? bits : 0;
                    rnd  = int'($urandom & 15);
                    if (sg == 4) begin
                        if (w == 1) inv = (bits << 1) | (~bits & 1) | (rnd & 12);
                        else if (w == 2) inv = bits | (rnd & 12);
                        else inv = bits;
                    end else inv = rnd;
                    b_in.push_back(inv);
                    e_sclk.push_back(0); e_cs.push_back(0); e_oe.push_back(oe); e_out.push_back(outv); e_done.push_back(0);
                    e_sclk.push_back(1); e_cs.push_back(0); e_oe.push_back(oe); e_out.push_back(outv); e_done.push_back(0);
                end
            end
        end
        nb = b_in.size();
        empty = (nb == 0);
        if (!empty) begin
            for (int k = 0; k < 2; k++) begin
                e_sclk.push_back(0); e_cs.push_back(1); e_oe.push_back(0); e_out.push_back(0); e_done.push_back(0);
            end
        end
        e_sclk.push_back(0); e_cs.push_back(1); e_oe.push_back(0); e_out.push_back(0); e_done.push_back(1);
        n = e_sclk.size();
        qt = empty ? "R9" : "R7";

        @(negedge clk);
        mode = 3'(md);
        op_len = LEN_W'(ol); adr_len = LEN_W'(al); wr_len = LEN_W'(wl);
        hz_len = LEN_W'(hl); rd_len = LEN_W'(rl);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        got = 0;
        for (int c = 0; c < n; c++) begin
            chk(qt, "sclk", int'(sclk), e_sclk[c]);
            chk(empty ? "R9" : "R8", "cs_n", int'(cs_n), e_cs[c]);
            chk(e_oe[c] != 0 ? "R2" : "R4", "io_oe", int'(io_oe), e_oe[c]);
            chk("R1 R3", "io_out", int'(io_out & io_oe), e_out[c]);
            chk("R10", "busy", int'(busy), 1);
            chk(empty ? "R9" : "R8", "done", int'(done), e_done[c]);
            if (rx_valid) begin
                chk("R5", "rx_data", int'(rx_data), int'(rx_mem[got]));
                got++;
            end
            io_in = (c < 2 * nb) ? 4'(b_in[c / 2]) : 4'($urandom);
            // R10: a second start while busy must leave the waveform untouched
            start = poke && (c == 3) && (c + 2 < n);
            @(negedge clk);
        end
        start = 1'b0;
        chk("R10", "busy after done", int'(busy), 0);
        chk("R10", "done after done", int'(done), 0);
        chk("R8", "cs_n idle", int'(cs_n), 1);
        chk("R5", "read byte count", got, rl);
        chk("R6", "take count", take_cnt - base, ol + al + wl);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog: busy actual %0d expected 0", int'(busy));
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int k = 0; k < 256; k++) tx_mem[k] = 8'($urandom);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R7", "sclk reset", int'(sclk), 0);
        chk("R8", "cs_n reset", int'(cs_n), 1);
        chk("R10", "busy reset", int'(busy), 0);
        chk("R10", "done reset", int'(done), 0);
        chk("R4", "io_oe reset", int'(io_oe), 0);

        run_cmd(0, 1, 3, 0, 0, 2, 1'b0);   // single lane read, R5 lane 1
        run_cmd(1, 1, 3, 0, 1, 4, 1'b0);   // dual data only
        run_cmd(2, 1, 3, 0, 2, 3, 1'b0);   // dual address and data, R4 dummy
        run_cmd(3, 1, 3, 0, 1, 2, 1'b1);   // quad data, start poked while busy (R10)
        run_cmd(4, 1, 3, 0, 3, 2, 1'b0);   // quad address and data
        run_cmd(5, 1, 3, 0, 2, 2, 1'b0);   // all phases on four lanes
        run_cmd(0, 1, 3, 4, 0, 0, 1'b0);   // write command, R6
        run_cmd(4, 0, 0, 2, 0, 1, 1'b0);   // skipped segments, R1
        run_cmd(3, 0, 0, 0, 0, 0, 1'b0);   // empty command, R9
        run_cmd(5, 1, 0, 0, 0, 0, 1'b0);   // opcode only on four lanes
        run_cmd(1, 0, 0, 0, 2, 0, 1'b0);   // dummy only, R4
        run_cmd(2, 2, 2, 2, 1, 2, 1'b0);   // every segment present, R1

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule